// File: doc/BRIEF.md
# Machine ISA-Extension and Exception-PC Register Unit

This block holds a small group of machine-mode control registers for a 64-bit core: the ISA-extension register, the floating-point state and XLEN fields of the status register, the two counter-enable registers, the three identity registers, and the machine and supervisor exception-PC registers. Software reaches them through one read/write port made of a 12-bit address, a 64-bit write-data bus and a write strobe. Reads are combinational from the current state. Writes land on the clock edge where the strobe is high.

Two behaviours tie the registers to the instruction stream. First, a write that would switch off the compressed-instruction flag is refused while the next-PC input is not 8-byte aligned. The other written bits still take effect. Second, reads of either exception-PC register hide the low address bits according to the compressed flag as it stands now. With the flag set, only bit 0 is hidden. With it clear, bits 1:0 are hidden. The stored value itself is never changed by this.

A parameter selects the 64-bit layout, which is the default, or the 32-bit layout of the XLEN field.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, address 0x301 reads 0x8000_0000_0014_112D. This is the XLEN field (bits 63:62) equal to 2, plus the flags for A(0), C(2), D(3), F(5), I(8), M(12), S(18) and U(20). All other flags are 0.
- R2: After reset, address 0x300 reads 0x0000_000A_0000_2000. This is FS (bits 14:13) = 1, UXL (33:32) = 2 and SXL (35:34) = 2. All other bits are 0.
- R3: After reset, 0x306 and 0x106 read 0x7. Addresses 0xF11, 0xF12 and 0xF13 always read 0.
- R4: A write to 0x301 stores bits 63:62 and flag bits 25:0 as written, except as R5 states. All other bits read as 0.
- R5: If a write to 0x301 has bit 2 clear while next_pc[2:0] is nonzero, the C flag (bit 2) keeps its current value. The rest of the write is still accepted.
- R6: If next_pc[2:0] is zero, a write to 0x301 may clear C. A write that sets C is always accepted.
- R7: While C is set, reads of 0x341 and 0x141 return the stored value with bit 0 cleared.
- R8: While C is clear, reads of 0x341 and 0x141 return the stored value with bits 1:0 cleared. Setting C again shows the stored bit 1 again.
- R9: A write to 0x300 changes only FS (bits 14:13). UXL and SXL stay at 2, and all other bits stay 0.
- R10: Writes to 0x306 and 0x106 store bits 31:0. Bits 63:32 read 0.
- R11: With the strobe low, nothing changes. A write to an unassigned address changes nothing, and an unassigned address reads 0.
- R12: Read data reflects the state before the edge. A write becomes visible only after the clock edge that commits it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address for both reads and writes |
| csr_wdata | input | 64 | Write data |
| csr_we | input | 1 | Write strobe; the write commits on the rising edge |
| next_pc | input | 64 | Address of the next instruction, used by the C-flag guard |
| csr_rdata | output | 64 | Combinational read data for csr_addr |

## Verification
The extension-register write guard and the combinational read port act in the same cycle. When the strobe is high for address 0x301, the port also returns that register's value, and the guard decides C from next_pc during that same cycle. The bench holds such a write with a misaligned next_pc and samples the read data before the edge, expecting the old value. After the edge it expects the new flags with C unchanged. Aligned and misaligned next_pc values are then compared in back-to-back writes, and exception-PC reads taken right after each C transition show that the masking follows the updated flag.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XW       = 64;
    localparam int FLAG_W   = 26;
    localparam int C_POS    = 2;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_MCNTEN  = 12'h306;
    localparam logic [11:0] A_SCNTEN  = 12'h106;
    localparam logic [11:0] A_MEPC    = 12'h341;
    localparam logic [11:0] A_SEPC    = 12'h141;
    localparam logic [11:0] A_VENDOR  = 12'hF11;
    localparam logic [11:0] A_ARCH    = 12'hF12;
    localparam logic [11:0] A_IMPL    = 12'hF13;

    // letters I M A F D C plus privilege flags S U
    localparam logic [FLAG_W-1:0] FLAGS_RESET =
        (FLAG_W'(1) << 8)  | (FLAG_W'(1) << 12) | (FLAG_W'(1) << 0) |
        (FLAG_W'(1) << 5)  | (FLAG_W'(1) << 3)  | (FLAG_W'(1) << C_POS) |
        (FLAG_W'(1) << 18) | (FLAG_W'(1) << 20);

    localparam logic [1:0] FS_INITIAL = 2'd1;

    typedef struct packed {
        logic [1:0]        mxl;
        logic [FLAG_W-1:0] flags;
    } ext_t;

    // Guard: refuse to drop C while the following fetch is not 8-byte aligned
    function automatic logic [FLAG_W-1:0] guard_flags(
        input logic [FLAG_W-1:0] cur,
        input logic [FLAG_W-1:0] req,
        input logic [2:0]        npc_low
    );
        logic [FLAG_W-1:0] res;
        res = req;
        if (!req[C_POS] && (npc_low != 3'b000))
            res[C_POS] = cur[C_POS];
        return res;
    endfunction

    // Exception-PC view depends on the live C flag
    function automatic logic [XW-1:0] epc_view(
        input logic [XW-1:0] stored,
        input logic          c_on
    );
        logic [XW-1:0] keep;
        keep = c_on ? ~XW'(1) : ~XW'(3);
        return stored & keep;
    endfunction

endpackage

// File: rtl/mcsr_ext_reg.sv
module mcsr_ext_reg
    import mcsr_pkg::*;
#(
    parameter bit RV64 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [XW-1:0] wdata,
    input  logic [2:0]    npc_low,
    output logic [XW-1:0] rd_value,
    output logic          c_on
);
    localparam logic [1:0] MXL_RESET = RV64 ? 2'd2 : 2'd1;

    ext_t       cur;
    logic [1:0] mxl_req;

    generate
        if (RV64) begin : g_wide
            assign mxl_req  = wdata[63:62];
            assign rd_value = {cur.mxl, 36'b0, cur.flags};
        end else begin : g_narrow
            assign mxl_req  = wdata[31:30];
            assign rd_value = {32'b0, cur.mxl, 4'b0, cur.flags};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.mxl   <= MXL_RESET;
            cur.flags <= FLAGS_RESET;
        end else if (wr_en) begin
            cur.mxl   <= mxl_req;
            cur.flags <= guard_flags(cur.flags, wdata[FLAG_W-1:0], npc_low);
        end
    end

    assign c_on = cur.flags[C_POS];
endmodule

// File: rtl/mcsr_status_fields.sv
module mcsr_status_fields
    import mcsr_pkg::*;
#(
    parameter bit RV64 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] rd_value
);
    localparam logic [1:0] XL_FIXED = RV64 ? 2'd2 : 2'd0;

    logic [1:0] fs_q;

    always_ff @(posedge clk) begin
        if (rst)        fs_q <= FS_INITIAL;
        else if (wr_en) fs_q <= wdata[14:13];
    end

    assign rd_value = {28'b0, XL_FIXED, XL_FIXED, 17'b0, fs_q, 13'b0};
endmodule

// File: rtl/mcsr_counten.sv
module mcsr_counten
    import mcsr_pkg::*;
#(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = W'(7)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] rd_value
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)        q <= RESET_VAL;
        else if (wr_en) q <= wdata[W-1:0];
    end

    assign rd_value = {{(XW-W){1'b0}}, q};
endmodule

// File: rtl/mcsr_epc_bank.sv
module mcsr_epc_bank
    import mcsr_pkg::*;
#(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] wr_sel,
    input  logic [XW-1:0]  wdata,
    input  logic           c_on,
    input  logic [((NUM>1)?$clog2(NUM):1)-1:0] rd_idx,
    output logic [XW-1:0]  rd_value
);
    logic [XW-1:0] slot [NUM];

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)            slot[i] <= '0;
                else if (wr_sel[i]) slot[i] <= wdata;
            end
        end
    endgenerate

    assign rd_value = epc_view(slot[rd_idx], c_on);
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
#(
    parameter bit RV64 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [11:0]   csr_addr,
    input  logic [63:0]   csr_wdata,
    input  logic          csr_we,
    input  logic [63:0]   next_pc,
    output logic [63:0]   csr_rdata
);
    localparam int NEPC = 2;   // slot 0 machine, slot 1 supervisor

    logic [XW-1:0] isa_rd, st_rd, mc_rd, sc_rd, epc_rd;
    logic          c_enabled;
    logic          hit_isa, hit_st, hit_mc, hit_sc;
    logic [NEPC-1:0] hit_epc;
    logic [0:0]    epc_idx;

    assign hit_isa    = csr_addr == A_ISA;
    assign hit_st     = csr_addr == A_STATUS;
    assign hit_mc     = csr_addr == A_MCNTEN;
    assign hit_sc     = csr_addr == A_SCNTEN;
    assign hit_epc[0] = csr_addr == A_MEPC;
    assign hit_epc[1] = csr_addr == A_SEPC;
    assign epc_idx    = hit_epc[1];

    mcsr_ext_reg #(.RV64(RV64)) u_ext (
        .clk(clk), .rst(rst), .wr_en(csr_we && hit_isa), .wdata(csr_wdata),
        .npc_low(next_pc[2:0]), .rd_value(isa_rd), .c_on(c_enabled)
    );

    mcsr_status_fields #(.RV64(RV64)) u_status (
        .clk(clk), .rst(rst), .wr_en(csr_we && hit_st), .wdata(csr_wdata),
        .rd_value(st_rd)
    );

    mcsr_counten #(.W(32), .RESET_VAL(32'h7)) u_mcnt (
        .clk(clk), .rst(rst), .wr_en(csr_we && hit_mc), .wdata(csr_wdata),
        .rd_value(mc_rd)
    );

    mcsr_counten #(.W(32), .RESET_VAL(32'h7)) u_scnt (
        .clk(clk), .rst(rst), .wr_en(csr_we && hit_sc), .wdata(csr_wdata),
        .rd_value(sc_rd)
    );

    mcsr_epc_bank #(.NUM(NEPC)) u_epc (
        .clk(clk), .rst(rst), .wr_sel(hit_epc & {NEPC{csr_we}}),
        .wdata(csr_wdata), .c_on(c_enabled), .rd_idx(epc_idx),
        .rd_value(epc_rd)
    );

    always_comb begin
        case (csr_addr)
            A_ISA:            csr_rdata = isa_rd;
            A_STATUS:         csr_rdata = st_rd;
            A_MCNTEN:         csr_rdata = mc_rd;
            A_SCNTEN:         csr_rdata = sc_rd;
            A_MEPC, A_SEPC:   csr_rdata = epc_rd;
            default:          csr_rdata = '0;  // identity regs and unassigned
        endcase
    end
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk
    import mcsr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [11:0] csr_addr,
    input logic [63:0] csr_wdata,
    input logic        csr_we,
    input logic [63:0] next_pc,
    input logic [63:0] csr_rdata,
    input logic        c_en
);
    logic is_epc;
    assign is_epc = (csr_addr == A_MEPC) || (csr_addr == A_SEPC);

    a_r5_c_kept: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == A_ISA && c_en && next_pc[2:0] != 3'b000) |=> c_en);

    a_r6_c_follows: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == A_ISA && next_pc[2:0] == 3'b000)
            |=> (c_en == $past(csr_wdata[C_POS])));

    a_r7_epc_bit0: assert property (@(posedge clk) disable iff (rst)
        is_epc |-> (csr_rdata[0] == 1'b0));

    a_r8_epc_bit1: assert property (@(posedge clk) disable iff (rst)
        (is_epc && !c_en) |-> (csr_rdata[1] == 1'b0));

    a_r3_id_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == A_VENDOR || csr_addr == A_ARCH || csr_addr == A_IMPL)
            |-> (csr_rdata == 64'd0));

    a_r3_cnt_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && csr_addr == A_MCNTEN) |-> (csr_rdata == 64'h7));
endmodule

bind mcsr_unit mcsr_unit_chk u_chk (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .next_pc(next_pc), .csr_rdata(csr_rdata),
    .c_en(c_enabled)
);

// File: tb/mcsr_unit_test.sv
module mcsr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [63:0] next_pc = '0;
    logic [63:0] csr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mcsr_unit uut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .next_pc(next_pc), .csr_rdata(csr_rdata)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [63:0] npc);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; next_pc = npc; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [63:0] exp);
        @(negedge clk);
        csr_addr = a; csr_we = 1'b0;
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1", 12'h301, 64'h8000_0000_0014_112D);
        rd_check("R2", 12'h300, 64'h0000_000A_0000_2000);
        rd_check("R3", 12'h306, 64'h7);
        rd_check("R3", 12'h106, 64'h7);
        rd_check("R3", 12'hF11, 64'h0);
        rd_check("R3", 12'hF12, 64'h0);
        rd_check("R3", 12'hF13, 64'h0);
        rd_check("R7", 12'h341, 64'h0);
    endtask

    task automatic t_isa_fields;
        wr(12'h301, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        rd_check("R4", 12'h301, 64'hC000_0000_03FF_FFFF);
        wr(12'h301, 64'h8000_0000_0014_112D, 64'h0);
        rd_check("R4", 12'h301, 64'h8000_0000_0014_112D);
    endtask

    task automatic t_guard;
        // same-cycle: read shows old value while the write is pending
        @(negedge clk);
        csr_addr = 12'h301; csr_wdata = 64'h8000_0000_0000_0101;
        next_pc = 64'h2; csr_we = 1'b1;
        #1;
        check("R12", csr_rdata, 64'h8000_0000_0014_112D);
        @(negedge clk);
        csr_we = 1'b0;
        rd_check("R5", 12'h301, 64'h8000_0000_0000_0105);
        wr(12'h301, 64'h8000_0000_0000_0101, 64'h4);
        rd_check("R5", 12'h301, 64'h8000_0000_0000_0105);
        wr(12'h301, 64'h8000_0000_0000_0101, 64'h8);
        rd_check("R6", 12'h301, 64'h8000_0000_0000_0101);
        wr(12'h301, 64'h8000_0000_0000_0105, 64'h6);
        rd_check("R6", 12'h301, 64'h8000_0000_0000_0105);
    endtask

    task automatic t_epc;
        wr(12'h341, 64'h0000_0000_1234_5677, 64'h0);
        wr(12'h141, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        rd_check("R7", 12'h341, 64'h0000_0000_1234_5676);
        rd_check("R7", 12'h141, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(12'h301, 64'h8000_0000_0000_0101, 64'h0);
        rd_check("R8", 12'h341, 64'h0000_0000_1234_5674);
        rd_check("R8", 12'h141, 64'hFFFF_FFFF_FFFF_FFFC);
        wr(12'h301, 64'h8000_0000_0000_0105, 64'h0);
        rd_check("R8", 12'h341, 64'h0000_0000_1234_5676);
    endtask

    task automatic t_status_cnt;
        wr(12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        rd_check("R9", 12'h300, 64'h0000_000A_0000_6000);
        wr(12'h300, 64'h0, 64'h0);
        rd_check("R9", 12'h300, 64'h0000_000A_0000_0000);
        wr(12'h306, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        rd_check("R10", 12'h306, 64'h0000_0000_FFFF_FFFF);
        wr(12'h106, 64'h5, 64'h0);
        rd_check("R10", 12'h106, 64'h5);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        csr_addr = 12'h306; csr_wdata = 64'h0; csr_we = 1'b0;
        @(negedge clk);
        rd_check("R11", 12'h306, 64'h0000_0000_FFFF_FFFF);
        wr(12'h7C0, 64'h0, 64'h0);
        rd_check("R11", 12'h7C0, 64'h0);
        rd_check("R11", 12'h306, 64'h0000_0000_FFFF_FFFF);
        rd_check("R11", 12'h106, 64'h5);
        rd_check("R11", 12'h301, 64'h8000_0000_0000_0105);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_isa_fields();
        t_guard();
        t_epc();
        t_status_cnt();
        t_ignored();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule